// File: doc/BRIEF.md
# Masked-Field Repeating Alarm

This block compares a programmed alarm time against the running BCD time of a separate clock block and produces a one-cycle interrupt pulse when the alarm is due. The alarm holds four byte registers: seconds, minutes, hours and day of month. Bit 7 of each register is a repeat mask. A set mask bit turns that field into a don't-care.

The mask bits choose how often the alarm repeats. The repeat rate is one of month, day, hour, minute or second. Only the nested patterns give the slower rates. The date field is masked first, then the hour, then the minute. Any other pattern makes the alarm fire on every second.

Software writes the registers over a simple byte bus. Each write is checked against the legal BCD range of its field before it is stored. The clock block supplies a strobe once per second. The comparison is made only on that strobe, so one matching second gives one pulse. A single enable bit in a control register gates the pulse.

Top module: `alarm_match_top`

## Requirements
- R1: After reset, every alarm register and the control register read 0x00, and `irq` is low.
- R2: Register addresses are: 0 = alarm seconds, 1 = alarm minutes, 2 = alarm hours, 3 = alarm date, 4 = control.
  - In each alarm register, bit 7 is the mask bit.
  - The value occupies bits 6:0 for seconds and minutes, and bits 5:0 for hours and date.
  - Any other bits are stored as 0.
  - In the control register, only bit 0 (interrupt enable) is stored.
  - Addresses 5 to 7 read 0x00.
  - `rd_data` follows `rd_addr` combinationally.
- R3: A seconds or minutes write is stored only if its value bits form valid BCD (each digit no greater than 9) in the range 00 to 59. Otherwise the register keeps its old contents.
- R4: An hours write is stored only if its value bits are valid BCD in the range 00 to 23. Otherwise the register is unchanged.
- R5: A date write is stored only if its value bits are valid BCD in the range 01 to 31. A zero value is rejected even when the mask bit is set.
- R6: With no mask bits set, a tick produces a pulse only when date, hour, minute and second all match.
- R7: With only the date mask set, a tick produces a pulse when hour, minute and second match, whatever the date.
- R8: With the date and hour masks set, a tick produces a pulse when minute and second match.
- R9: With the date, hour and minute masks set, a tick produces a pulse when the second matches.
- R10: Every other mask pattern makes every tick produce a pulse, whatever the current time.
- R11: A pulse appears on `irq` in the cycle after a qualifying `sec_tick`. It lasts exactly one cycle. No pulse occurs without a tick.
- R12: While the enable bit is 0, a matching tick produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_addr | input | 3 | Write register address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read register address |
| rd_data | output | 8 | Read data for `rd_addr` |
| cur_sec | input | 8 | Current seconds, BCD |
| cur_min | input | 8 | Current minutes, BCD |
| cur_hour | input | 8 | Current hours, BCD |
| cur_date | input | 8 | Current day of month, BCD |
| sec_tick | input | 1 | One-cycle strobe once per second |
| irq | output | 1 | Alarm interrupt pulse |

## Verification
The assertions assume that `sec_tick` is a single-cycle strobe that is never high in two consecutive cycles. Without that, the one-cycle-pulse property could not hold. They also assume that the current-time inputs are stable around a tick. The bench drives every tick as an isolated one-cycle strobe. It changes the time inputs only between ticks, and applies writes only on cycles without a tick.

// File: rtl/alarm_match_pkg.sv
package alarm_match_pkg;
  localparam int BYTE_W    = 8;
  localparam int FIELD_CNT = 4;
  localparam int ADR_CTRL  = 4;

  typedef enum logic [2:0] {
    RATE_MONTH, RATE_DAY, RATE_HOUR, RATE_MINUTE, RATE_SECOND
  } rate_e;

  // Value bits of a field: seconds/minutes have 7, hours/date have 6.
  function automatic logic [7:0] value_mask(input int idx);
    return (idx < 2) ? 8'h7F : 8'h3F;
  endfunction

  function automatic int unsigned field_lo(input int idx);
    return (idx == 3) ? 1 : 0;
  endfunction

  function automatic int unsigned field_hi(input int idx);
    case (idx)
      0, 1:    return 59;
      2:       return 23;
      default: return 31;
    endcase
  endfunction

  function automatic logic bcd_ok(input logic [7:0] v, input int unsigned lo,
                                  input int unsigned hi);
    int unsigned bin;
    bin = 32'(v[7:4]) * 10 + 32'(v[3:0]);
    return (v[3:0] <= 4'd9) && (v[7:4] <= 4'd9) && (bin >= lo) && (bin <= hi);
  endfunction

  // Fields that must match, bit 0 = seconds ... bit 3 = date.
  function automatic logic [3:0] care_of(input rate_e r);
    case (r)
      RATE_MONTH:  return 4'b1111;
      RATE_DAY:    return 4'b0111;
      RATE_HOUR:   return 4'b0011;
      RATE_MINUTE: return 4'b0001;
      default:     return 4'b0000;
    endcase
  endfunction
endpackage

// File: rtl/alarm_regs.sv
module alarm_regs
  import alarm_match_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [ADDR_W-1:0]               wr_addr,
  input  logic [BYTE_W-1:0]               wr_data,
  input  logic [ADDR_W-1:0]               rd_addr,
  output logic [BYTE_W-1:0]               rd_data,
  output logic [FIELD_CNT-1:0][BYTE_W-1:0] alarm_q,
  output logic                            irq_en,
  output logic                            wr_accept
);
  localparam logic [ADDR_W-1:0] FLD_LAST = ADDR_W'(FIELD_CNT - 1);
  localparam logic [ADDR_W-1:0] CTRL_A   = ADDR_W'(ADR_CTRL);

  logic field_sel;
  logic range_ok;

  assign field_sel = wr_addr <= FLD_LAST;

  always_comb begin
    int idx;
    idx      = int'(wr_addr);
    range_ok = bcd_ok(wr_data & value_mask(idx), field_lo(idx), field_hi(idx));
  end

  assign wr_accept = wr_en && ((field_sel && range_ok) || (wr_addr == CTRL_A));

  for (genvar g = 0; g < FIELD_CNT; g++) begin : g_field
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        alarm_q[g] <= '0;
      else if (wr_accept && wr_addr == ADDR_W'(g))
        alarm_q[g] <= wr_data & (value_mask(g) | 8'h80);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      irq_en <= 1'b0;
    else if (wr_accept && wr_addr == CTRL_A)
      irq_en <= wr_data[0];
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr <= FLD_LAST)
      rd_data = alarm_q[rd_addr[1:0]];
    else if (rd_addr == CTRL_A)
      rd_data = {{(BYTE_W-1){1'b0}}, irq_en};
  end
endmodule

// File: rtl/alarm_rate_decode.sv
module alarm_rate_decode
  import alarm_match_pkg::*;
(
  input  logic [FIELD_CNT-1:0] mask_bits,
  output rate_e                rate
);
  // Only nested patterns (date, then hour, then minute) select slower rates.
  always_comb begin
    case (mask_bits)
      4'b0000: rate = RATE_MONTH;
      4'b1000: rate = RATE_DAY;
      4'b1100: rate = RATE_HOUR;
      4'b1110: rate = RATE_MINUTE;
      default: rate = RATE_SECOND;
    endcase
  end
endmodule

// File: rtl/alarm_compare.sv
module alarm_compare
  import alarm_match_pkg::*;
(
  input  logic [FIELD_CNT-1:0][BYTE_W-1:0] alarm_q,
  input  logic [FIELD_CNT-1:0][BYTE_W-1:0] cur_time,
  input  rate_e                            rate,
  output logic                             match_hit
);
  logic [FIELD_CNT-1:0] care;
  logic [FIELD_CNT-1:0] field_eq;

  assign care = care_of(rate);

  for (genvar g = 0; g < FIELD_CNT; g++) begin : g_cmp
    assign field_eq[g] = !care[g] ||
                         (((alarm_q[g] ^ cur_time[g]) & value_mask(g)) == 8'h00);
  end

  assign match_hit = &field_eq;
endmodule

// File: rtl/alarm_match_top.sv
module alarm_match_top
  import alarm_match_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  input  logic [7:0]        cur_sec,
  input  logic [7:0]        cur_min,
  input  logic [7:0]        cur_hour,
  input  logic [7:0]        cur_date,
  input  logic              sec_tick,
  output logic              irq
);
  logic [FIELD_CNT-1:0][BYTE_W-1:0] alarm_q;
  logic [FIELD_CNT-1:0][BYTE_W-1:0] cur_time;
  logic [FIELD_CNT-1:0]             mask_bits;
  logic                             irq_en;
  logic                             wr_accept;
  logic                             match_hit;
  logic                             fire;
  rate_e                            rate_sel;

  assign cur_time = {cur_date, cur_hour, cur_min, cur_sec};

  alarm_regs #(.ADDR_W(ADDR_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .alarm_q(alarm_q), .irq_en(irq_en), .wr_accept(wr_accept)
  );

  for (genvar g = 0; g < FIELD_CNT; g++) begin : g_mask
    assign mask_bits[g] = alarm_q[g][BYTE_W-1];
  end

  alarm_rate_decode rate_i (.mask_bits(mask_bits), .rate(rate_sel));

  alarm_compare cmp_i (
    .alarm_q(alarm_q), .cur_time(cur_time), .rate(rate_sel), .match_hit(match_hit)
  );

  assign fire = sec_tick && match_hit && irq_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= fire;
  end
endmodule

// File: rtl/alarm_match_chk.sv
module alarm_match_chk
  import alarm_match_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             sec_tick,
  input logic                             irq,
  input logic                             irq_en,
  input logic                             match_hit,
  input rate_e                            rate_sel,
  input logic                             wr_en,
  input logic [ADDR_W-1:0]                wr_addr,
  input logic                             wr_accept,
  input logic [FIELD_CNT-1:0][BYTE_W-1:0] alarm_q
);
  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> (!irq && alarm_q == '0)); // R1
  AST_REJECT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr <= ADDR_W'(FIELD_CNT - 1) && !wr_accept) |=> $stable(alarm_q)); // R3
  AST_MATCH_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && irq_en && match_hit) |=> irq); // R6
  AST_SECOND_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && irq_en && rate_sel == RATE_SECOND) |=> irq); // R10
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) irq |=> !irq); // R11
  AST_IRQ_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(sec_tick)); // R11
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(irq_en)); // R12
endmodule

bind alarm_match_top alarm_match_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .irq(irq), .irq_en(irq_en),
  .match_hit(match_hit), .rate_sel(rate_sel), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_accept(wr_accept), .alarm_q(alarm_q)
);

// File: tb/alarm_match_top_tb_top.sv
module alarm_match_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic [7:0] cur_sec = 8'h30, cur_min = 8'h15, cur_hour = 8'h08, cur_date = 8'h12;
  logic       sec_tick = 1'b0;
  logic       irq;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  alarm_match_top dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .cur_sec(cur_sec), .cur_min(cur_min),
    .cur_hour(cur_hour), .cur_date(cur_date), .sec_tick(sec_tick), .irq(irq)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic write_reg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic read_chk(input logic [2:0] a, input logic [7:0] exp, input string tag);
    rd_addr = a; #1;
    chk(tag, rd_data, exp);
  endtask

  task automatic set_time(input logic [7:0] s, m, h, d);
    @(negedge clk); cur_sec = s; cur_min = m; cur_hour = h; cur_date = d;
  endtask

  // One-cycle tick; pulse expected in the next cycle, low in the one after.
  task automatic tick_chk(input logic exp, input string tag);
    @(negedge clk); sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0;
    chk({tag, " pulse"}, {7'b0, irq}, {7'b0, exp});
    @(negedge clk);
    chk({tag, " end"}, {7'b0, irq}, 8'h00);
  endtask

  task automatic load_alarm(input logic [7:0] s, m, h, d);
    write_reg(3'd0, s); write_reg(3'd1, m); write_reg(3'd2, h); write_reg(3'd3, d);
  endtask

  task automatic t_reset;
    for (int a = 0; a < 5; a++) read_chk(3'(a), 8'h00, "R1 reg after reset");
    chk("R1 irq after reset", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_map;
    write_reg(3'd2, 8'h48); read_chk(3'd2, 8'h08, "R2 hour bit6 dropped");
    write_reg(3'd0, 8'hD9); read_chk(3'd0, 8'hD9, "R2 sec mask kept");
    write_reg(3'd4, 8'hFF); read_chk(3'd4, 8'h01, "R2 ctrl bit0 only");
    read_chk(3'd6, 8'h00, "R2 unused addr");
  endtask

  task automatic t_range;
    write_reg(3'd0, 8'h59); read_chk(3'd0, 8'h59, "R3 sec 59 accepted");
    write_reg(3'd0, 8'h60); read_chk(3'd0, 8'h59, "R3 sec 60 rejected");
    write_reg(3'd1, 8'h42); write_reg(3'd1, 8'h3A); read_chk(3'd1, 8'h42, "R3 min bad digit");
    write_reg(3'd2, 8'h23); read_chk(3'd2, 8'h23, "R4 hour 23 accepted");
    write_reg(3'd2, 8'h24); read_chk(3'd2, 8'h23, "R4 hour 24 rejected");
    write_reg(3'd3, 8'h31); read_chk(3'd3, 8'h31, "R5 date 31 accepted");
    write_reg(3'd3, 8'h32); read_chk(3'd3, 8'h31, "R5 date 32 rejected");
    write_reg(3'd3, 8'h80); read_chk(3'd3, 8'h31, "R5 masked zero date rejected");
    write_reg(3'd3, 8'h00); read_chk(3'd3, 8'h31, "R5 zero date rejected");
  endtask

  task automatic t_month;
    load_alarm(8'h30, 8'h15, 8'h08, 8'h12);
    set_time(8'h30, 8'h15, 8'h08, 8'h12); tick_chk(1'b1, "R6 full match");
    set_time(8'h30, 8'h15, 8'h08, 8'h13); tick_chk(1'b0, "R6 date differs");
  endtask

  task automatic t_day;
    write_reg(3'd3, 8'h92);
    set_time(8'h30, 8'h15, 8'h08, 8'h05); tick_chk(1'b1, "R7 any date");
    set_time(8'h30, 8'h15, 8'h09, 8'h05); tick_chk(1'b0, "R7 hour differs");
  endtask

  task automatic t_hour;
    write_reg(3'd2, 8'h88);
    set_time(8'h30, 8'h15, 8'h09, 8'h05); tick_chk(1'b1, "R8 any hour");
    set_time(8'h30, 8'h16, 8'h09, 8'h05); tick_chk(1'b0, "R8 minute differs");
  endtask

  task automatic t_minute;
    write_reg(3'd1, 8'h95);
    set_time(8'h30, 8'h16, 8'h09, 8'h05); tick_chk(1'b1, "R9 any minute");
    set_time(8'h31, 8'h16, 8'h09, 8'h05); tick_chk(1'b0, "R9 second differs");
  endtask

  task automatic t_second;
    write_reg(3'd0, 8'hB0);
    tick_chk(1'b1, "R10 all masked");
    load_alarm(8'hB0, 8'h15, 8'h08, 8'h12);
    set_time(8'h01, 8'h02, 8'h03, 8'h04); tick_chk(1'b1, "R10 only sec masked");
    load_alarm(8'h30, 8'h95, 8'h08, 8'h92);
    tick_chk(1'b1, "R10 date and minute masked");
  endtask

  task automatic t_pulse;
    load_alarm(8'h30, 8'h15, 8'h08, 8'h12);
    set_time(8'h30, 8'h15, 8'h08, 8'h12);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); chk("R11 no pulse without tick", {7'b0, irq}, 8'h00);
    end
    tick_chk(1'b1, "R11 single pulse");
  endtask

  task automatic t_enable;
    write_reg(3'd4, 8'h00);
    tick_chk(1'b0, "R12 disabled");
    write_reg(3'd4, 8'h01);
    tick_chk(1'b1, "R12 re-enabled");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_map();
    t_range();
    write_reg(3'd4, 8'h01);
    t_month();
    t_day();
    t_hour();
    t_minute();
    t_second();
    t_pulse();
    t_enable();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule